// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Pin Interrupts

This block is an eight-pin general-purpose I/O port on a simple synchronous register bus. The bus carries a byte address, a write strobe and eight bits of write data, and returns read data combinationally for the address on the bus. Each pin can be an input or an output. Data accesses use an address-encoded bit mask, so software can read or change a subset of pins with one access and no read-modify-write sequence.

Each pin has its own interrupt detector. Inputs first pass through a two-flop synchroniser. Detection is programmable per pin:

- level-sensitive, with active-high or active-low polarity;
- edge-sensitive on rising edges or on falling edges;
- edge-sensitive on both edges.

Latched edge events stay set until software writes ones to a clear register. Software can read raw status and status gated by the enable register. One combined interrupt line goes high when any enabled status bit is set.

Top module: `mmio_gpio`

## Requirements
- R1: After reset, every control register and every status register reads 0. `pin_oe_o`, `pin_o` and `irq_o` are 0.
- R2: The direction register is at offset 0x400, and bit n belongs to pin n. A 1 makes the pin an output and drives `pin_oe_o[n]` high. The register reads back what was written.
- R3: A write to the data window (offsets 0x000 to 0x3FC) takes its mask m from address bits [9:2]. Output latch bit n takes `wdata_i[n]` only when m[n]=1 and pin n is an output. Every other latch bit keeps its value. `pin_o` shows the latch.
- R4: A read in the data window returns m AND view. For each pin, view is the output latch bit if the pin is an output, and the synchronised `pin_i` bit if it is an input. Bits outside m read 0.
- R5: `pin_i` passes through two flops. A change applied between edges shows in data reads and level status after the second rising edge. A latched edge status bit sets on the third rising edge.
- R6: With sense bit = 1 (offset 0x404), the raw status bit is level-sensitive. It equals the synchronised pin when the event bit (0x40C) is 1, and the inverted pin when the event bit is 0. Writing the clear register has no effect on it.
- R7: With sense = 0 and both-edges = 0 (0x408), an event bit of 1 latches the status bit on a rising edge and 0 latches it on a falling edge.
- R8: With sense = 0 and both-edges = 1, either transition latches the status bit, whatever the event bit holds.
- R9: Writing ones to the clear register (0x41C) clears the matching latched edge bits and leaves the other bits as they were. An edge detected in the same cycle as its clear leaves the bit set.
- R10: Masked status (0x418) is raw status (0x414) AND the enable register (0x410). `irq_o` is the OR of all masked status bits.
- R11: Writes to the raw status and masked status offsets have no effect. The clear register always reads 0.
- R12: Reads of unmapped offsets return 0. The unmapped offsets are 0x420 to 0x7FC and every address from 0x800 up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| pin_o | output | 8 | Output latch value |
| pin_oe_o | output | 8 | Output enable per pin (direction register) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sweeps all 256 data-window masks for both writes and reads, under two mixed direction patterns.

- **Writes:** a design that let a write reach an input pin's latch, or that ignored the mask, drives the wrong `pin_o`.
- **Reads:** leaking bits outside the mask, or returning the latch in place of the pin for an input, gives a wrong read value.

Five interrupt configurations, from uniform to mixed per pin, are driven through pin patterns against an arithmetic model.

- **Polarity and mode:** a polarity swapped, or the event bit honoured in both-edges mode, shows as a wrong raw status value.
- **Level mode and clear:** a level bit that a clear write can drop also shows as a wrong raw status value.

The bench also times a clear write to land in the same cycle as a new edge. A design where clear wins there loses that event. A probe of the synchroniser depth catches a one-stage or three-stage path.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;
  // control page register index, taken from address bits [4:2]
  typedef enum logic [2:0] {
    REG_DIR   = 3'd0,
    REG_SENSE = 3'd1,
    REG_BOTH  = 3'd2,
    REG_EVENT = 3'd3,
    REG_IEN   = 3'd4,
    REG_RAW   = 3'd5,
    REG_MSK   = 3'd6,
    REG_CLR   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/mmio_gpio_sync.sv
module mmio_gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mmio_gpio_det.sv
module mmio_gpio_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic event_i,
  input  logic clr_i,
  output logic raw_o,
  output logic edge_o
);
  logic prev_q, edge_q;
  logic rise, fall, hit;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;
  assign hit  = ~sense_i & (both_i ? (rise | fall) : (event_i ? rise : fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      edge_q <= hit | (edge_q & ~clr_i); // a new event beats its clear
    end
  end

  assign raw_o  = sense_i ? ~(lvl_i ^ event_i) : edge_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
  import mmio_gpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  localparam int PAGE_LSB = NPINS + 2;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  logic [PAGE_W-1:0] page;
  logic              data_sel, ctrl_sel;
  logic [NPINS-1:0]  acc_mask;
  reg_idx_e          idx;
  logic              addr_unused;

  assign page        = addr_i[ADDR_W-1:PAGE_LSB];
  assign acc_mask    = addr_i[NPINS+1:2];
  assign data_sel    = (page == '0);
  assign ctrl_sel    = (page == PAGE_W'(1)) && (addr_i[PAGE_LSB-1:5] == '0);
  assign idx         = reg_idx_e'(addr_i[4:2]);
  assign addr_unused = ^addr_i[1:0];

  logic [NPINS-1:0] dir_q, sense_q, both_q, event_q, ien_q, out_q;
  logic [NPINS-1:0] wr_mask, clr_vec;

  assign wr_mask = acc_mask & dir_q;
  assign clr_vec = (we_i && ctrl_sel && idx == REG_CLR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      ien_q   <= '0;
      out_q   <= '0;
    end else if (we_i) begin
      if (data_sel) out_q <= (out_q & ~wr_mask) | (wdata_i & wr_mask);
      if (ctrl_sel) begin
        case (idx)
          REG_DIR:   dir_q   <= wdata_i;
          REG_SENSE: sense_q <= wdata_i;
          REG_BOTH:  both_q  <= wdata_i;
          REG_EVENT: event_q <= wdata_i;
          REG_IEN:   ien_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  logic [NPINS-1:0] pin_sync, raw_vec, edge_vec, msk_vec, pin_view;

  mmio_gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_det
    mmio_gpio_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (pin_sync[g]),
      .sense_i(sense_q[g]),
      .both_i (both_q[g]),
      .event_i(event_q[g]),
      .clr_i  (clr_vec[g]),
      .raw_o  (raw_vec[g]),
      .edge_o (edge_vec[g])
    );
  end

  assign msk_vec  = raw_vec & ien_q;
  assign irq_o    = |msk_vec;
  assign pin_view = (dir_q & out_q) | (~dir_q & pin_sync);
  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  always_comb begin
    rdata_o = '0;
    if (data_sel) begin
      rdata_o = acc_mask & pin_view;
    end else if (ctrl_sel) begin
      case (idx)
        REG_DIR:   rdata_o = dir_q;
        REG_SENSE: rdata_o = sense_q;
        REG_BOTH:  rdata_o = both_q;
        REG_EVENT: rdata_o = event_q;
        REG_IEN:   rdata_o = ien_q;
        REG_RAW:   rdata_o = raw_vec;
        REG_MSK:   rdata_o = msk_vec;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_gpio_chk.sv
module mmio_gpio_chk #(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  rdata_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  ien_q,
  input logic [NPINS-1:0]  out_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  edge_vec,
  input logic [NPINS-1:0]  clr_vec
);
  localparam int CLR_OFF = (1 << (NPINS + 2)) + 28;

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  assert_input_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

  assert_edge_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(edge_vec) & ~edge_vec & ~$past(clr_vec)) == '0));

  assert_clear_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(CLR_OFF)) |-> (rdata_o == '0));

  assert_read_outside_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:NPINS+2] == '0) |-> ((rdata_o & ~addr_i[NPINS+1:2]) == '0));

  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1:NPINS+3] != '0) |-> (rdata_o == '0));
endmodule

bind mmio_gpio mmio_gpio_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .ien_q   (ien_q),
  .out_q   (out_q),
  .dir_q   (dir_q),
  .edge_vec(edge_vec),
  .clr_vec (clr_vec)
);

// File: tb/mmio_gpio_tb.sv
`timescale 1ns/1ps
module mmio_gpio_tb;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_EVENT = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni, we, irq;
  logic [11:0] addr;
  logic [7:0]  wdata, rdata, pin, pin_out, pin_oe;

  mmio_gpio u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  logic [7:0] m_dir, m_out, m_prev, m_edge, m_sense, m_both, m_event, m_ien, rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] raw_model(input logic [7:0] v);
    return (m_sense & ~(v ^ m_event)) | (~m_sense & m_edge);
  endfunction

  task automatic apply_pin(input logic [7:0] v);
    logic [7:0] rise, fall, hit;
    @(negedge clk);
    pin = v;
    settle();
    rise = v & ~m_prev;
    fall = ~v & m_prev;
    hit = ~m_sense & ((m_both & (rise | fall)) | (~m_both & m_event & rise) |
                      (~m_both & ~m_event & fall));
    m_edge = m_edge | hit;
    m_prev = v;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; we = 1'b0; addr = '0; wdata = '0; pin = '0;
    m_dir = '0; m_out = '0; m_edge = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pin_oe", {24'd0, pin_oe}, 0);
    chk("R1 pin_o", {24'd0, pin_out}, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    for (int i = 0; i < 8; i++) begin
      rd(12'h400 + 12'(i * 4), rv);
      chk("R1 ctrl reg", {24'd0, rv}, 0);
    end
    rd(12'h3FC, rv);
    chk("R1 data", {24'd0, rv}, 0);

    // R2 direction
    wr(A_DIR, 8'h3C); m_dir = 8'h3C;
    rd(A_DIR, rv);
    chk("R2 readback", {24'd0, rv}, 32'h3C);
    chk("R2 pin_oe", {24'd0, pin_oe}, 32'h3C);

    // R3 masked writes, all masks, two direction patterns
    for (int p = 0; p < 2; p++) begin
      m_dir = (p == 0) ? 8'h3C : 8'hC5;
      wr(A_DIR, m_dir);
      for (int m = 0; m < 256; m++) begin
        logic [7:0] d, mk;
        mk = 8'(m);
        d = 8'((m * 29 + 7 + p * 90) & 255);
        wr({2'b00, mk, 2'b00}, d);
        m_out = (m_out & ~(mk & m_dir)) | (d & mk & m_dir);
        chk("R3 pin_o", {24'd0, pin_out}, {24'd0, m_out});
      end
    end

    // R4 masked reads
    @(negedge clk) pin = 8'h96;
    settle();
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mk;
      mk = 8'(m);
      rd({2'b00, mk, 2'b00}, rv);
      chk("R4 read", {24'd0, rv}, {24'd0, mk & ((m_dir & m_out) | (~m_dir & 8'h96))});
    end

    // R5 synchroniser depth
    wr(A_DIR, 8'h00); m_dir = 8'h00;
    @(negedge clk) begin pin = 8'h00; addr = 12'h3FC; end
    settle();
    @(negedge clk) pin = 8'hFF;
    @(posedge clk); @(negedge clk); #1;
    chk("R5 after one edge", {24'd0, rdata}, 0);
    @(posedge clk); @(negedge clk); #1;
    chk("R5 after two edges", {24'd0, rdata}, 32'hFF);
    @(negedge clk) pin = 8'h00;
    settle();
    m_prev = 8'h00;

    // R6/R7/R8/R9/R10 interrupt configurations
    for (int c = 0; c < 5; c++) begin
      string tag;
      case (c)
        0: begin m_sense = 8'h00; m_both = 8'h00; m_event = 8'hFF; m_ien = 8'hFF; tag = "R7 rising"; end
        1: begin m_sense = 8'h00; m_both = 8'h00; m_event = 8'h00; m_ien = 8'hFF; tag = "R7 falling"; end
        2: begin m_sense = 8'h00; m_both = 8'hFF; m_event = 8'h5A; m_ien = 8'hFF; tag = "R8 both"; end
        3: begin m_sense = 8'hFF; m_both = 8'h00; m_event = 8'h0F; m_ien = 8'hFF; tag = "R6 level"; end
        default: begin m_sense = 8'h33; m_both = 8'h0C; m_event = 8'hA5; m_ien = 8'h6B; tag = "R7 mixed"; end
      endcase
      apply_pin(8'h00);
      wr(A_SENSE, m_sense); wr(A_BOTH, m_both); wr(A_EVENT, m_event); wr(A_IEN, m_ien);
      wr(A_CLR, 8'hFF); m_edge = 8'h00;
      for (int k = 0; k < 12; k++) begin
        logic [7:0] v, cl;
        v = 8'((k * 77 + c * 19 + 13) & 255);
        apply_pin(v);
        rd(A_RAW, rv);
        chk(tag, {24'd0, rv}, {24'd0, raw_model(v)});
        rd(A_MSK, rv);
        chk("R10 masked", {24'd0, rv}, {24'd0, raw_model(v) & m_ien});
        chk("R10 irq", {31'd0, irq}, {31'd0, |(raw_model(v) & m_ien)});
        if (k % 2 == 1) begin
          cl = 8'((k * 45) & 255);
          wr(A_CLR, cl);
          m_edge = m_edge & ~cl;
          rd(A_RAW, rv);
          chk("R9 clear", {24'd0, rv}, {24'd0, raw_model(v)});
        end
      end
    end

    // R9 clear landing with a new edge
    wr(A_SENSE, 8'h00); wr(A_BOTH, 8'h00); wr(A_EVENT, 8'hFF); wr(A_IEN, 8'h00);
    @(negedge clk) pin = 8'h00;
    settle();
    wr(A_CLR, 8'hFF);
    @(negedge clk) pin = 8'h01;
    @(posedge clk); @(posedge clk);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, rv);
    chk("R9 edge beats clear", {24'd0, rv}, 32'h01);
    chk("R10 irq disabled", {31'd0, irq}, 0);

    // R11 read-only and write-only offsets
    wr(A_RAW, 8'hFF); wr(A_MSK, 8'hFF);
    rd(A_RAW, rv);
    chk("R11 raw write ignored", {24'd0, rv}, 32'h01);
    wr(A_IEN, 8'h01);
    rd(A_MSK, rv);
    chk("R11 masked value", {24'd0, rv}, 32'h01);
    rd(A_CLR, rv);
    chk("R11 clear reads zero", {24'd0, rv}, 0);

    // R12 unmapped offsets
    rd(12'h420, rv); chk("R12 0x420", {24'd0, rv}, 0);
    rd(12'h7FC, rv); chk("R12 0x7FC", {24'd0, rv}, 0);
    rd(12'h800, rv); chk("R12 0x800", {24'd0, rv}, 0);
    rd(12'hFFC, rv); chk("R12 0xFFC", {24'd0, rv}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule